// File: doc/BRIEF.md
# Dual-Modulus Prescaler (P/P+1, P = 8 or 32)

This block divides a fast input clock by one of two neighbouring ratios, P or P+1, and emits one single-clock pulse each time a full division cycle completes. The pulse train is meant to clock a pair of downstream swallow and main counters, which steer the ratio through a modulus-control input. A configuration input selects the base modulus: 8, giving 8/9 operation, or 32, giving 32/33 operation.

The divider is built around a synchronous counter that divides by 4 or 5. A chain of divide-by-2 extension stages follows it: one stage in 8/9 mode, three stages in 32/33 mode. The core takes its fifth state only in a swallow cycle, and only once per cycle, during the pass in which every active extension stage is at its terminal value.

Both control inputs are sampled only at a cycle boundary, so a division cycle is never cut short or stretched partway through. After reset the block spends one clock loading its controls, then starts its first cycle.

Top module: `dmod_prescaler`

## Requirements
- R1: With `swallow` = 0 latched for a cycle, consecutive rising pulses on `div_pulse` are P input clocks apart.
- R2: With `swallow` = 1 latched for a cycle, consecutive pulses are P+1 input clocks apart.
- R3: `sel_p32` = 0 selects P = 8 and `sel_p32` = 1 selects P = 32.
- R4: `div_pulse` is high for exactly one input clock per division cycle.
- R5: `swallow` and `sel_p32` are sampled only at the clock edge where `div_pulse` rises (and at the load clock after reset). A change at any other time first affects the cycle after the one in progress.
- R6: While `rst_n` is low, `div_pulse` is low, and it drops without waiting for a clock edge. The first clock edge after release loads the controls. The first pulse then goes high N+1 clocks after release, where N is the ratio that was loaded.
- R7: The spacing between pulses is always 8, 9, 32 or 33 input clocks, so the output rate never exceeds one eighth of the input rate.
- R8: The 4/5 core enters its fifth state only in a swallow cycle, at most once per cycle, and returns to state 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_p32 | input | 1 | Base modulus select: 0 for P=8, 1 for P=32 |
| swallow | input | 1 | Modulus control: 0 divides by P, 1 divides by P+1 |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
A core that takes its fifth state in the wrong pass, or an extension stage that toggles out of turn, shows up as a pulse spacing other than 8, 9, 32 or 33. This is visible at the very next pulse, at most 33 clocks later. A control latch that updates partway through a cycle shows up as a spacing that fits neither the old setting nor the new one, within the cycle in which the change was made. A lost load clock after reset moves the first pulse away from N+1 clocks after release.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  // Number of divide-by-2 stages behind the 4/5 core in each mode.
  localparam int unsigned STG_LO = 1;   // 4 * 2^1 = 8
  localparam int unsigned STG_HI = 3;   // 4 * 2^3 = 32
  localparam int unsigned STG_MAX = (STG_HI > STG_LO) ? STG_HI : STG_LO;
  localparam int unsigned CORE_W = 3;   // holds states 0..4

  localparam logic [CORE_W-1:0] CORE_LAST4 = CORE_W'(3);
  localparam logic [CORE_W-1:0] CORE_FIFTH = CORE_W'(4);

  function automatic logic [STG_MAX-1:0] stage_mask(input logic hi);
    logic [STG_MAX-1:0] m;
    for (int i = 0; i < int'(STG_MAX); i++)
      m[i] = (i < int'(hi ? STG_HI : STG_LO));
    return m;
  endfunction
endpackage

// File: rtl/dmod_core45.sv
module dmod_core45
  import dmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              take_fifth,
  output logic              wrap,
  output logic [CORE_W-1:0] state
);
  logic [CORE_W-1:0] state_q;
  logic [CORE_W-1:0] state_d;

  always_comb begin
    wrap    = (state_q == CORE_FIFTH) ||
              ((state_q == CORE_LAST4) && !take_fifth);
    state_d = state_q;
    if (run_en) state_d = wrap ? '0 : state_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/dmod_ext_chain.sv
module dmod_ext_chain #(
  parameter int unsigned NSTG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [NSTG-1:0] active,
  output logic            terminal
);
  logic [NSTG-1:0] bit_q;
  logic [NSTG-1:0] bit_d;
  logic [NSTG:0]   carry;

  assign carry[0] = adv;

  for (genvar i = 0; i < int'(NSTG); i++) begin : g_stage
    assign carry[i+1] = carry[i] & bit_q[i];
    always_comb begin
      bit_d[i] = bit_q[i];
      if (carry[i] && active[i]) bit_d[i] = ~bit_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= '0;
    else        bit_q <= bit_d;
  end

  assign terminal = &(bit_q | ~active);
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_p32,
  input  logic swallow,
  output logic div_pulse
);
  logic              load_q;
  logic              mod_q, mod_d;
  logic              swl_q, swl_d;
  logic              pulse_q, pulse_d;
  logic              core_wrap;
  logic [CORE_W-1:0] core_st;
  logic              ext_term;
  logic              bound;
  logic              run_en;
  logic [STG_MAX-1:0] act_mask;

  assign run_en   = !load_q;
  assign act_mask = stage_mask(mod_q);

  dmod_core45 u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .take_fifth (swl_q && ext_term),
    .wrap       (core_wrap),
    .state      (core_st)
  );

  dmod_ext_chain #(.NSTG(STG_MAX)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (core_wrap && run_en),
    .active   (act_mask),
    .terminal (ext_term)
  );

  always_comb begin
    bound   = run_en && core_wrap && ext_term;
    mod_d   = mod_q;
    swl_d   = swl_q;
    if (load_q || bound) begin
      mod_d = sel_p32;
      swl_d = swallow;
    end
    pulse_d = bound;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b1;
      mod_q   <= 1'b0;
      swl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      mod_q   <= mod_d;
      swl_q   <= swl_d;
      pulse_q <= pulse_d;
    end
  end

  assign div_pulse = pulse_q;
endmodule

// File: rtl/dmod_prescaler_chk.sv
module dmod_prescaler_chk
  import dmod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              div_pulse,
  input logic              swl_q,
  input logic              mod_q,
  input logic              load_q,
  input logic              bound,
  input logic [CORE_W-1:0] core_st
);
  logic [6:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (div_pulse) begin
      gap_q  <= 7'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 7'h7f) begin
      gap_q  <= gap_q + 7'd1;
    end
  end

  // R4
  pulse_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R7
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && seen_q) |->
      (gap_q == 7'd8 || gap_q == 7'd9 || gap_q == 7'd32 || gap_q == 7'd33));

  // R8
  core_fifth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_st == CORE_FIFTH) |-> swl_q);

  // R8
  core_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_st == CORE_FIFTH) |=> (core_st == '0));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_q) |-> $past(bound || load_q));

  // R5
  swallow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swl_q) |-> $past(bound || load_q));
endmodule

bind dmod_prescaler dmod_prescaler_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_pulse (div_pulse),
  .swl_q     (swl_q),
  .mod_q     (mod_q),
  .load_q    (load_q),
  .bound     (bound),
  .core_st   (core_st)
);

// File: tb/dmod_prescaler_test.sv
module dmod_prescaler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_p32 = 1'b0;
  logic swallow = 1'b0;
  logic div_pulse;

  int checks = 0;
  int failures = 0;
  int min_gap = 1000;
  int n;

  always #5 clk = ~clk;

  dmod_prescaler uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_p32   (sel_p32),
    .swallow   (swallow),
    .div_pulse (div_pulse)
  );

  // {sel_p32, swallow, expected spacing}
  localparam logic [7:0] VEC [0:7] = '{
    {1'b0, 1'b0, 6'd8},  {1'b0, 1'b1, 6'd9},
    {1'b1, 1'b0, 6'd32}, {1'b1, 1'b1, 6'd33},
    {1'b0, 1'b0, 6'd8},  {1'b1, 1'b1, 6'd33},
    {1'b0, 1'b1, 6'd9},  {1'b1, 1'b0, 6'd32}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling edges until div_pulse is seen high.
  task automatic measure(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!div_pulse && cnt < 100);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 pulse low in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    measure(n);
    check("R6 first pulse after release P=8", n, 9);
    @(negedge clk);
    check("R4 pulse width", int'(div_pulse), 0);

    // R1 R2 R3 R8: table walk
    for (int i = 0; i < 8; i++) begin
      sel_p32 = VEC[i][7];
      swallow = VEC[i][6];
      measure(n);
      measure(n);
      if (n < min_gap) min_gap = n;
      check(VEC[i][6] ? "R2/R8 P+1 spacing" : "R1/R3 P spacing",
            n, int'(VEC[i][5:0]));
    end
    check("R7 minimum spacing", int'(min_gap >= 8), 1);

    @(negedge clk);
    check("R4 pulse width P=32", int'(div_pulse), 0);

    // R5: mid-cycle changes act only on the next cycle
    sel_p32 = 1'b0; swallow = 1'b0;
    measure(n);
    measure(n);
    @(negedge clk);
    swallow = 1'b1;
    measure(n);
    check("R5 swallow change ignored mid-cycle", n, 7);
    measure(n);
    check("R5 swallow takes effect next cycle", n, 9);
    @(negedge clk);
    sel_p32 = 1'b1; swallow = 1'b0;
    measure(n);
    check("R5 select change ignored mid-cycle", n, 8);
    measure(n);
    check("R5 R3 select takes effect next cycle", n, 32);

    // R6: asynchronous reset while pulse is high, then restart at 33
    measure(n);
    rst_n = 1'b0;
    #1;
    check("R6 async clear of pulse", int'(div_pulse), 0);
    swallow = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    measure(n);
    check("R6 first pulse after release P=33", n, 34);
    @(negedge clk);
    check("R4 pulse width P=33", int'(div_pulse), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule